// File: doc/BRIEF.md
# Scan Port Instruction Register and Data-Path Selector

This block holds the instruction of a serial test port and decides, from that instruction, which data register lies between the serial input and the serial output. An instruction is shifted in one bit per test clock, least significant bit first. An update strobe then copies it into a held stage. Only the held stage drives the decoded controls, so the test-mode controls do not pass through intermediate values while the instruction is being shifted. The port's state machine is outside this block. It supplies separate capture, shift and update strobes for the instruction path and for the data path. Each strobe is sampled at the rising test clock.

The decoded instruction selects one of three data registers: a single-cell bypass register, the boundary register, or an identification register. The boundary and identification registers are outside this block. Their serial outputs come in, and the block gates their capture, shift and update strobes so that only the selected register responds. The block also drives two controls for the boundary cells. One connects the pads to the boundary register, for board wiring tests. The other connects the core inputs to the boundary register, for testing the core. A sampling instruction selects the boundary register and leaves both controls in the normal position. The serial output and its enable are retimed on the falling test clock.

Instruction codes (3 bits): 000 pad test, 001 sample/preload, 010 core test, 011 identification, 111 bypass. Every other code is decoded as bypass. When the identification register is left out by parameter, 011 is also decoded as bypass.

Top module: `scan_ir_ctrl`

## Requirements
- R1: While trst_n is low, the held instruction is 011 (identification), so sel_ident is 1 and sel_bypass and sel_boundary are 0. In the same state tdo_en and tdo are 0. This reset acts without a clock edge.
- R2: At a rising tck with capture_ir high, the instruction shift stage loads the pattern 001: bit 0 is 1 and every higher bit is 0. With shift_ir high in the following cycles, tdo then presents 1, then 0, then 0.
- R3: At each rising tck with shift_ir high and capture_ir low, the shift stage moves one place toward bit 0 and tdi enters the top bit. During a cycle with shift_ir high, tdo shows the current bit 0.
- R4: At a rising tck with update_ir high, the held instruction takes the value of the shift stage. At every other edge the held instruction, and so every decoded output, stays unchanged, even while new bits are shifted in.
- R5: Code 111 and the undefined codes 100, 101 and 110 select the bypass cell: sel_bypass is 1, and sel_boundary, sel_ident, pad_test and core_test are 0. Exactly one of the three selects is 1 at all times.
- R6: When the bypass cell is selected, it loads 0 at a rising tck with capture_dr high. At a rising tck with shift_dr high it loads tdi, so during a DR shift tdo repeats tdi from one cycle earlier.
- R7: Code 000 selects the boundary register with pad_test 1 and core_test 0.
- R8: Code 010 selects the boundary register with core_test 1 and pad_test 0.
- R9: Code 001 selects the boundary register with pad_test 0 and core_test 0.
- R10: Code 011 selects the identification register, and during a DR shift tdo follows id_so.
- R11: tdo and tdo_en change only at the falling tck. tdo_en is 1 exactly when shift_ir or shift_dr is high at that edge, and otherwise tdo is 0. If both shift strobes are high, shift_ir has priority. During a DR shift with the boundary register selected, tdo follows bsr_so.
- R12: bsr_capture, bsr_shift and bsr_update equal capture_dr, shift_dr and update_dr while the boundary register is selected, and 0 otherwise. id_capture and id_shift equal capture_dr and shift_dr while the identification register is selected, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial test data in |
| capture_ir | input | 1 | Instruction capture strobe |
| shift_ir | input | 1 | Instruction shift strobe |
| update_ir | input | 1 | Instruction update strobe |
| capture_dr | input | 1 | Data-register capture strobe |
| shift_dr | input | 1 | Data-register shift strobe |
| update_dr | input | 1 | Data-register update strobe |
| bsr_so | input | 1 | Serial output of the boundary register |
| id_so | input | 1 | Serial output of the identification register |
| tdo | output | 1 | Serial test data out, retimed on the falling clock |
| tdo_en | output | 1 | Output enable for tdo |
| sel_bypass | output | 1 | Bypass cell is the selected data register |
| sel_boundary | output | 1 | Boundary register is the selected data register |
| sel_ident | output | 1 | Identification register is the selected data register |
| pad_test | output | 1 | Pads driven from the boundary register |
| core_test | output | 1 | Core inputs driven from the boundary register |
| bsr_capture | output | 1 | Gated capture strobe for the boundary register |
| bsr_shift | output | 1 | Gated shift strobe for the boundary register |
| bsr_update | output | 1 | Gated update strobe for the boundary register |
| id_capture | output | 1 | Gated capture strobe for the identification register |
| id_shift | output | 1 | Gated shift strobe for the identification register |

## Verification
On every cycle, the assertions check four things: exactly one data register is selected, the two test-mode controls are never both on, the held instruction keeps its value unless an update strobe arrives, and the capture pattern and bypass cell load what they should. They also check that tdo is 0 whenever its enable is off. Only the bench scenarios can show that each code maps to the right data register and mode, and that the bits reach tdo in the right order and with the right delay. The same applies to the one-cycle bypass delay, to the priority between the two shift strobes, and to the asynchronous reset arriving in the middle of a run.

// File: rtl/scan_ir_pkg.sv
`timescale 1ns/1ps
package scan_ir_pkg;

    // Instruction values below the all-ones bypass code
    localparam int OP_PADTEST  = 0;
    localparam int OP_SAMPLE   = 1;
    localparam int OP_CORETEST = 2;
    localparam int OP_IDENT    = 3;

    typedef enum logic [1:0] {
        DR_BYPASS   = 2'd0,
        DR_BOUNDARY = 2'd1,
        DR_IDENT    = 2'd2
    } dr_sel_e;

    typedef struct packed {
        dr_sel_e dr;
        logic    pad_test;
        logic    core_test;
    } ir_dec_t;

endpackage

// File: rtl/ir_shift_hold.sv
`timescale 1ns/1ps
module ir_shift_hold #(
    parameter int                IR_W       = 3,
    parameter logic [IR_W-1:0]   RESET_CODE = '1
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            capture,
    input  logic            shift,
    input  logic            update,
    output logic            lsb,
    output logic [IR_W-1:0] instr
);

    // Capture pattern: bit 0 set, bit 1 clear, upper bits clear
    localparam logic [IR_W-1:0] CAP_PAT = IR_W'(1);

    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] hold;
    } ir_state_t;

    ir_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture) begin
            st_d.sh = CAP_PAT;
        end else if (shift) begin
            st_d.sh = {tdi, st_q.sh[IR_W-1:1]};
        end
        if (update) begin
            st_d.hold = st_q.sh;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            st_q.sh   <= CAP_PAT;
            st_q.hold <= RESET_CODE;
        end else begin
            st_q <= st_d;
        end
    end

    assign lsb   = st_q.sh[0];
    assign instr = st_q.hold;

    assert_capture_pattern_R2: assert property (@(posedge tck) disable iff (!trst_n)
        capture |=> (st_q.sh[1:0] == 2'b01));

    assert_hold_stable_R4: assert property (@(posedge tck) disable iff (!trst_n)
        !update |=> $stable(instr));

endmodule

// File: rtl/ir_decode.sv
`timescale 1ns/1ps
module ir_decode
    import scan_ir_pkg::*;
#(
    parameter int IR_W   = 3,
    parameter bit HAS_ID = 1'b1
) (
    input  logic [IR_W-1:0] instr,
    output ir_dec_t         dec
);

    always_comb begin
        dec.dr        = DR_BYPASS;
        dec.pad_test  = 1'b0;
        dec.core_test = 1'b0;
        if (instr == IR_W'(OP_PADTEST)) begin
            dec.dr       = DR_BOUNDARY;
            dec.pad_test = 1'b1;
        end else if (instr == IR_W'(OP_SAMPLE)) begin
            dec.dr = DR_BOUNDARY;
        end else if (instr == IR_W'(OP_CORETEST)) begin
            dec.dr        = DR_BOUNDARY;
            dec.core_test = 1'b1;
        end else if (HAS_ID && instr == IR_W'(OP_IDENT)) begin
            dec.dr = DR_IDENT;
        end
    end

endmodule

// File: rtl/bypass_cell.sv
`timescale 1ns/1ps
module bypass_cell (
    input  logic tck,
    input  logic trst_n,
    input  logic tdi,
    input  logic capture,
    input  logic shift,
    output logic q
);

    typedef struct packed {
        logic bit_v;
    } byp_state_t;

    byp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture) begin
            st_d.bit_v = 1'b0;
        end else if (shift) begin
            st_d.bit_v = tdi;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            st_q.bit_v <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.bit_v;

    assert_byp_capture_R6: assert property (@(posedge tck) disable iff (!trst_n)
        capture |=> !q);

    assert_byp_shift_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (shift && !capture) |=> (q == $past(tdi)));

endmodule

// File: rtl/tdo_retime.sv
`timescale 1ns/1ps
module tdo_retime (
    input  logic tck,
    input  logic trst_n,
    input  logic ir_shift,
    input  logic dr_shift,
    input  logic ir_bit,
    input  logic dr_bit,
    output logic tdo,
    output logic tdo_en
);

    typedef struct packed {
        logic data;
        logic en;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d.data = 1'b0;
        st_d.en   = 1'b0;
        if (ir_shift) begin
            st_d.data = ir_bit;
            st_d.en   = 1'b1;
        end else if (dr_shift) begin
            st_d.data = dr_bit;
            st_d.en   = 1'b1;
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            st_q.data <= 1'b0;
            st_q.en   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tdo    = st_q.data;
    assign tdo_en = st_q.en;

    assert_tdo_quiet_R11: assert property (@(negedge tck) disable iff (!trst_n)
        !tdo_en |-> !tdo);

    assert_tdo_enable_R11: assert property (@(negedge tck) disable iff (!trst_n)
        (ir_shift || dr_shift) |=> tdo_en);

endmodule

// File: rtl/scan_ir_ctrl.sv
`timescale 1ns/1ps
module scan_ir_ctrl
    import scan_ir_pkg::*;
#(
    parameter int IR_W   = 3,
    parameter bit HAS_ID = 1'b1
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tdi,
    input  logic capture_ir,
    input  logic shift_ir,
    input  logic update_ir,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic update_dr,
    input  logic bsr_so,
    input  logic id_so,
    output logic tdo,
    output logic tdo_en,
    output logic sel_bypass,
    output logic sel_boundary,
    output logic sel_ident,
    output logic pad_test,
    output logic core_test,
    output logic bsr_capture,
    output logic bsr_shift,
    output logic bsr_update,
    output logic id_capture,
    output logic id_shift
);

    localparam logic [IR_W-1:0] RST_CODE = HAS_ID ? IR_W'(OP_IDENT) : {IR_W{1'b1}};

    logic [IR_W-1:0] instr;
    logic            ir_lsb;
    logic            byp_q;
    logic            dr_bit;
    ir_dec_t         dec;

    ir_shift_hold #(
        .IR_W       (IR_W),
        .RESET_CODE (RST_CODE)
    ) u_ir (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .capture (capture_ir),
        .shift   (shift_ir),
        .update  (update_ir),
        .lsb     (ir_lsb),
        .instr   (instr)
    );

    ir_decode #(
        .IR_W   (IR_W),
        .HAS_ID (HAS_ID)
    ) u_dec (
        .instr (instr),
        .dec   (dec)
    );

    bypass_cell u_byp (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .capture (capture_dr && sel_bypass),
        .shift   (shift_dr && sel_bypass),
        .q       (byp_q)
    );

    always_comb begin
        sel_bypass   = (dec.dr == DR_BYPASS);
        sel_boundary = (dec.dr == DR_BOUNDARY);
        sel_ident    = (dec.dr == DR_IDENT);
        pad_test     = dec.pad_test;
        core_test    = dec.core_test;
        bsr_capture  = capture_dr && sel_boundary;
        bsr_shift    = shift_dr   && sel_boundary;
        bsr_update   = update_dr  && sel_boundary;
        id_capture   = capture_dr && sel_ident;
        id_shift     = shift_dr   && sel_ident;
        case (dec.dr)
            DR_BOUNDARY: dr_bit = bsr_so;
            DR_IDENT:    dr_bit = id_so;
            default:     dr_bit = byp_q;
        endcase
    end

    tdo_retime u_out (
        .tck      (tck),
        .trst_n   (trst_n),
        .ir_shift (shift_ir),
        .dr_shift (shift_dr),
        .ir_bit   (ir_lsb),
        .dr_bit   (dr_bit),
        .tdo      (tdo),
        .tdo_en   (tdo_en)
    );

    assert_one_select_R5: assert property (@(posedge tck) disable iff (!trst_n)
        $countones({sel_bypass, sel_boundary, sel_ident}) == 1);

    assert_modes_exclusive_R7: assert property (@(posedge tck) disable iff (!trst_n)
        !(pad_test && core_test));

    assert_mode_needs_boundary_R8: assert property (@(posedge tck) disable iff (!trst_n)
        (pad_test || core_test) |-> sel_boundary);

    assert_strobes_exclusive_R12: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({bsr_shift, id_shift}));

endmodule

// File: tb/scan_ir_ctrl_bench.sv
`timescale 1ns/1ps
module scan_ir_ctrl_bench;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tdi = 1'b0;
    logic capture_ir = 1'b0, shift_ir = 1'b0, update_ir = 1'b0;
    logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
    logic bsr_so = 1'b0, id_so = 1'b0;
    logic tdo, tdo_en, sel_bypass, sel_boundary, sel_ident, pad_test, core_test;
    logic bsr_capture, bsr_shift, bsr_update, id_capture, id_shift;

    int n_checks = 0;
    int n_errors = 0;

    always #5 tck = ~tck;

    scan_ir_ctrl u_scan_ir_ctrl (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .bsr_so(bsr_so), .id_so(id_so),
        .tdo(tdo), .tdo_en(tdo_en),
        .sel_bypass(sel_bypass), .sel_boundary(sel_boundary), .sel_ident(sel_ident),
        .pad_test(pad_test), .core_test(core_test),
        .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
        .id_capture(id_capture), .id_shift(id_shift)
    );

    // ---------------- behavioural reference ----------------
    bit mq[$];
    int mhold;
    bit mbyp, mtdo, men;

    function automatic int mclass(int h);
        if (h == 3) return 2;
        if (h >= 0 && h <= 2) return 1;
        return 0;
    endfunction

    function automatic string dtag(int h);
        case (h)
            0: return "R7";
            1: return "R9";
            2: return "R8";
            3: return "R10";
            default: return "R5";
        endcase
    endfunction

    function automatic int qval();
        int v = 0;
        for (int i = 0; i < mq.size(); i++) v = v | (int'(mq[i]) << i);
        return v;
    endfunction

    always @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            mq = '{1'b1, 1'b0, 1'b0};
            mhold = 3;
            mbyp = 1'b0;
        end else begin
            int nh;
            int cls;
            cls = mclass(mhold);
            nh = mhold;
            if (update_ir) nh = qval();
            if (capture_ir) mq = '{1'b1, 1'b0, 1'b0};
            else if (shift_ir) begin
                void'(mq.pop_front());
                mq.push_back(tdi);
            end
            if (cls == 0) begin
                if (capture_dr) mbyp = 1'b0;
                else if (shift_dr) mbyp = tdi;
            end
            mhold = nh;
        end
    end

    always @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            mtdo = 1'b0;
            men = 1'b0;
        end else if (shift_ir) begin
            mtdo = mq[0];
            men = 1'b1;
        end else if (shift_dr) begin
            men = 1'b1;
            case (mclass(mhold))
                1: mtdo = bsr_so;
                2: mtdo = id_so;
                default: mtdo = mbyp;
            endcase
        end else begin
            mtdo = 1'b0;
            men = 1'b0;
        end
    end

    // ---------------- checking ----------------
    task automatic check(string req, string nm, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int c;
        string t;
        string ttag;
        c = mclass(mhold);
        t = dtag(mhold);
        check(t, "sel_bypass", sel_bypass, c == 0);
        check(t, "sel_boundary", sel_boundary, c == 1);
        check(t, "sel_ident", sel_ident, c == 2);
        check(t, "pad_test", pad_test, mhold == 0);
        check(t, "core_test", core_test, mhold == 2);
        check("R12", "bsr_capture", bsr_capture, capture_dr && c == 1);
        check("R12", "bsr_shift", bsr_shift, shift_dr && c == 1);
        check("R12", "bsr_update", bsr_update, update_dr && c == 1);
        check("R12", "id_capture", id_capture, capture_dr && c == 2);
        check("R12", "id_shift", id_shift, shift_dr && c == 2);
        check("R11", "tdo_en", tdo_en, men);
        if (shift_ir) ttag = "R3";
        else if (shift_dr && c == 0) ttag = "R6";
        else if (shift_dr && c == 2) ttag = "R10";
        else ttag = "R11";
        check(ttag, "tdo", tdo, mtdo);
    endtask

    // next-cycle input values, applied by cyc()
    logic n_ci, n_si, n_ui, n_cd, n_sd, n_ud, n_tdi, n_bso, n_iso;

    task automatic idle_next();
        n_ci = 0; n_si = 0; n_ui = 0; n_cd = 0; n_sd = 0; n_ud = 0;
        n_tdi = 0; n_bso = 0; n_iso = 0;
    endtask

    task automatic cyc();
        @(posedge tck);
        #2;
        capture_ir = n_ci; shift_ir = n_si; update_ir = n_ui;
        capture_dr = n_cd; shift_dr = n_sd; update_dr = n_ud;
        tdi = n_tdi; bsr_so = n_bso; id_so = n_iso;
        #6;
        compare_all();
    endtask

    task automatic load_ir(logic [2:0] code, bit check_cap);
        idle_next(); n_ci = 1; cyc();
        for (int i = 0; i < 3; i++) begin
            idle_next(); n_si = 1; n_tdi = code[i]; cyc();
            if (check_cap) check("R2", "capture bit on tdo", tdo, (i == 0));
        end
        idle_next(); n_ui = 1; cyc();
        idle_next(); cyc();
    endtask

    task automatic shift_dr_run(int n, logic [15:0] pat);
        idle_next(); n_cd = 1; cyc();
        for (int i = 0; i < n; i++) begin
            idle_next(); n_sd = 1; n_tdi = pat[i]; n_bso = pat[(i + 3) % 16];
            n_iso = pat[(i + 7) % 16]; cyc();
        end
        idle_next(); n_ud = 1; cyc();
        idle_next(); cyc();
    endtask

    initial begin
        #200000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        idle_next();
        #23;
        // R1 reset state
        check("R1", "reset sel_ident", sel_ident, 1'b1);
        check("R1", "reset sel_bypass", sel_bypass, 1'b0);
        check("R1", "reset tdo_en", tdo_en, 1'b0);
        check("R1", "reset tdo", tdo, 1'b0);
        @(posedge tck); #2 trst_n = 1'b1;
        idle_next(); cyc();

        // identification register shifting (R10)
        shift_dr_run(8, 16'hA5C3);

        // pad test with capture pattern check (R2, R7)
        load_ir(3'b000, 1'b1);
        check("R7", "pad_test after load", pad_test, 1'b1);
        shift_dr_run(6, 16'h3C96);

        // R4: shift new bits without update, decode unchanged
        idle_next(); n_ci = 1; cyc();
        for (int i = 0; i < 3; i++) begin
            idle_next(); n_si = 1; n_tdi = 1'b1; cyc();
        end
        idle_next(); cyc();
        check("R4", "no update keeps pad_test", pad_test, 1'b1);
        check("R4", "no update keeps sel_boundary", sel_boundary, 1'b1);
        idle_next(); n_ui = 1; cyc();
        idle_next(); cyc();
        check("R4", "update applies bypass", sel_bypass, 1'b1);

        // bypass one-cycle delay (R6)
        idle_next(); n_cd = 1; cyc();
        begin
            logic prev;
            logic [7:0] pat;
            pat = 8'b1011_0010;
            prev = 1'b0;
            for (int i = 0; i < 8; i++) begin
                idle_next(); n_sd = 1; n_tdi = pat[i]; cyc();
                check("R6", "bypass delayed tdi", tdo, prev);
                prev = pat[i];
            end
        end
        idle_next(); cyc();

        // sample and core test (R9, R8)
        load_ir(3'b001, 1'b0);
        check("R9", "sample modes off", pad_test | core_test, 1'b0);
        shift_dr_run(5, 16'h6E21);
        load_ir(3'b010, 1'b0);
        check("R8", "core_test on", core_test, 1'b1);
        shift_dr_run(5, 16'h9D4B);

        // undefined codes (R5)
        load_ir(3'b100, 1'b0);
        check("R5", "code 100 bypass", sel_bypass, 1'b1);
        shift_dr_run(4, 16'h00F5);
        load_ir(3'b101, 1'b0);
        check("R5", "code 101 bypass", sel_bypass, 1'b1);
        load_ir(3'b110, 1'b0);
        check("R5", "code 110 bypass", sel_bypass, 1'b1);
        load_ir(3'b111, 1'b0);
        check("R5", "code 111 bypass", sel_bypass, 1'b1);

        // R11 priority: both shift strobes high, IR bit wins
        load_ir(3'b011, 1'b0);
        idle_next(); n_ci = 1; cyc();
        idle_next(); n_si = 1; n_sd = 1; n_iso = 1'b0; cyc();
        check("R11", "shift_ir priority tdo", tdo, 1'b1);
        check("R11", "shift_ir priority en", tdo_en, 1'b1);
        idle_next(); cyc();
        check("R11", "enable off when idle", tdo_en, 1'b0);

        // R1 asynchronous reset mid-run from pad test
        load_ir(3'b000, 1'b0);
        @(posedge tck); #2 trst_n = 1'b0;
        #6;
        check("R1", "async reset sel_ident", sel_ident, 1'b1);
        check("R1", "async reset pad_test", pad_test, 1'b0);
        check("R1", "async reset tdo_en", tdo_en, 1'b0);
        @(posedge tck); #2 trst_n = 1'b1;
        idle_next(); cyc();
        shift_dr_run(4, 16'h5A5A);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule